// File: doc/BRIEF.md
# Serial Configuration Loader

This block configures a downstream programmable device through its slave-serial port, using a stream of configuration bytes. A one-cycle `start` pulse, together with a total byte count, begins a run. The block first pulses the device's active-low program line. It then waits a clear delay and checks that the device's done line is still low. Next it takes bytes over a valid/ready input. Every byte before the first 0xFF marker is thrown away. From the marker on, each byte is shifted out on a serial data line against a slow configuration clock, most-significant bit first.

After the payload the block gives the device a fixed number of extra clock pulses. It then waits a settle delay and reads the done line once more. The result is posted as a 2-bit status code with a one-cycle completion pulse. Every clock phase lasts a whole number of system clock cycles, set by a parameter, so that the configuration clock meets the target's timing.

Top module: `cfg_serial_loader`

## Requirements
- R1: While not busy, `cfg_prog_n` is 1, `cfg_cclk` is 0, `cfg_din` is 0 and `in_ready` is 0; this is also the state after reset.
- R2: The cycle after an accepted `start`, `cfg_prog_n` goes low for PHASE_CYC cycles. It then returns high and the block waits CLR_DLY cycles. `cfg_done` is sampled on the last of those cycles.
- R3: If `cfg_done` is 1 at the end of the clear delay, the run ends with status 1 (done at wrong level) and no configuration clock pulse is issued.
- R4: Bytes accepted before the first byte equal to 0xFF are consumed but not shifted out. The 0xFF byte is the first one transmitted. Skipped bytes count toward `byte_cnt`.
- R5: Each transmitted bit is bit 7 down to bit 0 of its byte. A bit takes three phases of PHASE_CYC cycles each: data valid with the clock low, then the clock high, then the clock low. `cfg_din` changes only while the clock is low and outside the falling-edge cycle.
- R6: After the last byte, exactly TRAIL_CLK (5) further clock pulses follow, each a high phase and then a low phase, with `cfg_din` holding its final value.
- R7: After the trailing pulses the block waits FIN_DLY cycles and samples `cfg_done`. A value of 1 posts status 0 (ok) and a value of 0 posts status 2 (load failed).
- R8: If `byte_cnt` runs out before a 0xFF byte is seen, no data bit is shifted and the trailing pulses begin at once. A count of 0 skips the byte phase entirely.
- R9: `in_ready` is 1 only while the block waits for a byte (header search, or between payload bytes). A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1.
- R10: `busy` is 1 from the cycle after an accepted `start` until the cycle in which the status is posted. A `start` received while busy has no effect on the run.
- R11: `cpl` is 1 for exactly the one cycle in which `busy` falls. `status` holds its value while idle, and it is reset to 0 when a new run is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request, taken only while idle |
| byte_cnt | input | LEN_W | Total bytes of the run, header included, latched at start |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DW | Input byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| cfg_prog_n | output | 1 | Active-low program line to the target |
| cfg_cclk | output | 1 | Configuration clock to the target |
| cfg_din | output | 1 | Serial configuration data to the target |
| cfg_done | input | 1 | Done line from the target |
| busy | output | 1 | A run is in progress |
| cpl | output | 1 | One-cycle pulse when the status is posted |
| status | output | 2 | 0 ok, 1 done at wrong level, 2 load failed |

## Verification
The assertions assume that `cfg_done` is a clean, synchronous level and that `start` is not held high for long stretches. They also assume that a new run is requested only after the block has gone idle, with the exception of the deliberate start pulse sent during a run. The stimulus changes `cfg_done` only on falling edges. It keeps `cfg_done` at one level for the whole of the clear window and sets it to its final level early in the trailing pulses, so each sample point sees a settled value. Input bytes are offered only from a prepared stream and are held until the handshake completes. One run inserts idle gaps on `in_valid` to stretch the fetch wait.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   typedef enum logic [1:0] {
      CFG_OK        = 2'd0,
      CFG_DONE_HI   = 2'd1,
      CFG_LOAD_FAIL = 2'd2
   } cfg_stat_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PROG,
      S_CLEAR,
      S_HUNT,
      S_BSET,
      S_BHI,
      S_BLO,
      S_FETCH,
      S_THI,
      S_TLO,
      S_FINAL
   } ld_state_e;

endpackage

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         last
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic          shift,
   input  logic [DW-1:0] par_in,
   output logic          ser,
   output logic          last
);

   localparam int BW = $clog2(DW);

   logic [DW-1:0] sh_q;
   logic [BW-1:0] bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         bit_q <= '0;
      end else if (clr) begin
         sh_q  <= '0;
         bit_q <= '0;
      end else if (load) begin
         sh_q  <= par_in;
         bit_q <= BW'(DW - 1);
      end else if (shift) begin
         sh_q  <= {sh_q[DW-2:0], 1'b0};
         bit_q <= bit_q - 1'b1;
      end
   end

   assign ser  = sh_q[DW-1];
   assign last = (bit_q == '0);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfgld_pkg::*;
#(
   parameter int          LEN_W     = 16,
   parameter int          DW        = 8,
   parameter int          PHASE_CYC = 2,
   parameter int          CLR_DLY   = 50,
   parameter int          FIN_DLY   = 100,
   parameter int          TRAIL_CLK = 5,
   parameter logic [DW-1:0] MARK    = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] byte_cnt,
   input  logic             in_valid,
   input  logic [DW-1:0]    in_data,
   output logic             in_ready,
   output logic             cfg_prog_n,
   output logic             cfg_cclk,
   output logic             cfg_din,
   input  logic             cfg_done,
   output logic             busy,
   output logic             cpl,
   output logic [1:0]       status
);

   localparam int TMAX = (CLR_DLY > FIN_DLY) ?
                         ((CLR_DLY > PHASE_CYC) ? CLR_DLY : PHASE_CYC) :
                         ((FIN_DLY > PHASE_CYC) ? FIN_DLY : PHASE_CYC);
   localparam int TW   = $clog2(TMAX + 1);
   localparam int TRW  = $clog2(TRAIL_CLK + 1);
   localparam logic [TW-1:0] T_PH  = TW'(PHASE_CYC - 1);
   localparam logic [TW-1:0] T_CLR = TW'(CLR_DLY - 1);
   localparam logic [TW-1:0] T_FIN = TW'(FIN_DLY - 1);

   generate
      if (PHASE_CYC < 1 || CLR_DLY < 1 || FIN_DLY < 1) begin : g_bad_timing
         $error("cfg_serial_loader: phase and delay lengths must be at least 1");
      end
      if (TRAIL_CLK < 1 || DW < 2 || LEN_W < 1) begin : g_bad_shape
         $error("cfg_serial_loader: TRAIL_CLK, DW or LEN_W out of range");
      end
   endgenerate

   ld_state_e        st_q, st_d;
   logic [LEN_W-1:0] rem_q;
   logic [TRW-1:0]   tr_q;
   cfg_stat_e        stat_q;
   logic             cpl_q;

   logic             t_load, t_last;
   logic [TW-1:0]    t_val;
   logic             s_clr, s_load, s_shift, s_ser, s_last;
   logic             rem_ld, rem_dec, tr_ld, tr_dec, post;
   cfg_stat_e        post_code;
   logic             take;

   cfgld_timer #(.W(TW)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (t_load),
      .val  (t_val),
      .last (t_last)
   );

   cfgld_shifter #(.DW(DW)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (s_clr),
      .load  (s_load),
      .shift (s_shift),
      .par_in(in_data),
      .ser   (s_ser),
      .last  (s_last)
   );

   assign in_ready = (st_q == S_HUNT) || (st_q == S_FETCH);
   assign take     = in_ready && in_valid;

   always_comb begin
      st_d      = st_q;
      t_load    = 1'b0;
      t_val     = T_PH;
      s_clr     = 1'b0;
      s_load    = 1'b0;
      s_shift   = 1'b0;
      rem_ld    = 1'b0;
      rem_dec   = 1'b0;
      tr_ld     = 1'b0;
      tr_dec    = 1'b0;
      post      = 1'b0;
      post_code = CFG_OK;
      unique case (st_q)
         S_IDLE: if (start) begin
            st_d   = S_PROG;
            t_load = 1'b1;
            rem_ld = 1'b1;
         end
         S_PROG: if (t_last) begin
            st_d   = S_CLEAR;
            t_load = 1'b1;
            t_val  = T_CLR;
         end
         S_CLEAR: if (t_last) begin
            if (cfg_done) begin
               st_d      = S_IDLE;
               post      = 1'b1;
               post_code = CFG_DONE_HI;
               s_clr     = 1'b1;
            end else if (rem_q == '0) begin
               st_d   = S_THI;
               t_load = 1'b1;
               tr_ld  = 1'b1;
            end else begin
               st_d = S_HUNT;
            end
         end
         S_HUNT: if (take) begin
            rem_dec = 1'b1;
            if (in_data == MARK) begin
               st_d   = S_BSET;
               s_load = 1'b1;
               t_load = 1'b1;
            end else if (rem_q == LEN_W'(1)) begin
               st_d   = S_THI;
               t_load = 1'b1;
               tr_ld  = 1'b1;
            end
         end
         S_FETCH: if (take) begin
            rem_dec = 1'b1;
            st_d    = S_BSET;
            s_load  = 1'b1;
            t_load  = 1'b1;
         end
         S_BSET: if (t_last) begin
            st_d   = S_BHI;
            t_load = 1'b1;
         end
         S_BHI: if (t_last) begin
            st_d   = S_BLO;
            t_load = 1'b1;
         end
         S_BLO: if (t_last) begin
            if (!s_last) begin
               st_d    = S_BSET;
               s_shift = 1'b1;
               t_load  = 1'b1;
            end else if (rem_q == '0) begin
               st_d   = S_THI;
               t_load = 1'b1;
               tr_ld  = 1'b1;
            end else begin
               st_d = S_FETCH;
            end
         end
         S_THI: if (t_last) begin
            st_d   = S_TLO;
            t_load = 1'b1;
         end
         S_TLO: if (t_last) begin
            tr_dec = 1'b1;
            t_load = 1'b1;
            if (tr_q == TRW'(1)) begin
               st_d  = S_FINAL;
               t_val = T_FIN;
            end else begin
               st_d = S_THI;
            end
         end
         S_FINAL: if (t_last) begin
            st_d      = S_IDLE;
            post      = 1'b1;
            post_code = cfg_done ? CFG_OK : CFG_LOAD_FAIL;
            s_clr     = 1'b1;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         rem_q  <= '0;
         tr_q   <= '0;
         stat_q <= CFG_OK;
         cpl_q  <= 1'b0;
      end else begin
         st_q  <= st_d;
         cpl_q <= post;
         if (rem_ld)       rem_q <= byte_cnt;
         else if (rem_dec) rem_q <= rem_q - 1'b1;
         if (tr_ld)        tr_q  <= TRW'(TRAIL_CLK);
         else if (tr_dec)  tr_q  <= tr_q - 1'b1;
         if (rem_ld)       stat_q <= CFG_OK;
         else if (post)    stat_q <= post_code;
      end
   end

   assign busy       = (st_q != S_IDLE);
   assign cpl        = cpl_q;
   assign status     = stat_q;
   assign cfg_prog_n = (st_q != S_PROG);
   assign cfg_cclk   = (st_q == S_BHI) || (st_q == S_THI);
   assign cfg_din    = s_ser;

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       in_ready,
   input logic       cfg_prog_n,
   input logic       cfg_cclk,
   input logic       cfg_din,
   input logic       busy,
   input logic       cpl,
   input logic [1:0] status
);

   // R1
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cfg_prog_n && !cfg_cclk && !cfg_din && !in_ready));

   // R2
   prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_prog_n |-> (busy && !cfg_cclk && !in_ready));

   // R5
   din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cclk || $fell(cfg_cclk)) |-> $stable(cfg_din));

   // R9
   ready_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (busy && cfg_prog_n && !cfg_cclk));

   // R10
   start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R11
   cpl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpl |=> !cpl);

   // R11
   cpl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpl |-> (!busy && $past(busy) && status != 2'd3));

   // R11
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cpl) |-> $stable(status));

endmodule

bind cfg_serial_loader cfgld_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .in_ready  (in_ready),
   .cfg_prog_n(cfg_prog_n),
   .cfg_cclk  (cfg_cclk),
   .cfg_din   (cfg_din),
   .busy      (busy),
   .cpl       (cpl),
   .status    (status)
);

// File: tb/cfg_serial_loader_bench.sv
`timescale 1ns/1ps
module cfg_serial_loader_bench;

   localparam int PH  = 2;
   localparam int CLR = 50;
   localparam int FIN = 100;
   localparam int TRL = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] byte_cnt = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, cfg_prog_n, cfg_cclk, cfg_din, busy, cpl;
   logic        cfg_done = 1'b0;
   logic [1:0]  status;

   always #2 clk = ~clk;

   cfg_serial_loader #(.PHASE_CYC(PH), .CLR_DLY(CLR), .FIN_DLY(FIN), .TRAIL_CLK(TRL))
   u_cfg_serial_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din),
      .cfg_done(cfg_done), .busy(busy), .cpl(cpl), .status(status)
   );

   int vectors = 0;
   int miscompares = 0;

   // expected outputs, owned by the reference model
   logic       e_prog_n = 1'b1, e_cclk = 1'b0, e_din = 1'b0, e_rdy = 1'b0;
   logic       e_busy = 1'b0, e_cpl = 1'b0;
   logic [1:0] e_stat = 2'd0;
   bit         chk_en = 1'b0;

   // stimulus state
   logic [7:0] drv_q[$];
   logic [7:0] m_q[$];
   int         drv_idx = 0;
   int         gap_cnt = 0;
   bit         gap_mode = 1'b0;
   bit         pend = 1'b0;
   int         m_cnt = 0;
   int         m_stage = 0;
   bit         want_clear = 1'b0;
   bit         want_final = 1'b0;
   int         pulses = 0;
   logic       prev_cclk = 1'b0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (chk_en) begin
         check("R2 prog_n",  32'(cfg_prog_n), 32'(e_prog_n));
         check("R5 cclk",    32'(cfg_cclk),   32'(e_cclk));
         check("R4 din",     32'(cfg_din),    32'(e_din));
         check("R9 ready",   32'(in_ready),   32'(e_rdy));
         check("R10 busy",   32'(busy),       32'(e_busy));
         check("R11 cpl",    32'(cpl),        32'(e_cpl));
         check("R7 status",  32'(status),     32'(e_stat));
         if (cfg_cclk && !prev_cclk) pulses++;
         prev_cclk = cfg_cclk;
      end
   end

   // byte source and done-line driver
   always @(negedge clk) begin
      if (pend) begin
         drv_idx++;
         if (gap_mode) gap_cnt = 3;
      end
      if (gap_cnt > 0) begin
         in_valid = 1'b0;
         gap_cnt--;
      end else if (drv_idx < drv_q.size()) begin
         in_valid = 1'b1;
         in_data  = drv_q[drv_idx];
      end else begin
         in_valid = 1'b0;
      end
      pend = in_valid && in_ready;
      cfg_done = (m_stage == 2) ? want_final : want_clear;
   end

   task automatic m_finish(logic [1:0] code);
      e_prog_n = 1'b1; e_cclk = 1'b0; e_din = 1'b0; e_rdy = 1'b0;
      e_busy = 1'b0; e_cpl = 1'b1; e_stat = code;
      m_stage = 0;
      @(posedge clk);
      e_cpl = 1'b0;
   endtask

   // behavioural reference: entered right after the edge that takes start
   task automatic model_run();
      int rem = m_cnt;
      int k = 0;
      bit hunt = 1'b1;
      logic [7:0] b;
      m_stage = 1;
      e_busy = 1'b1; e_stat = 2'd0; e_cpl = 1'b0;
      e_prog_n = 1'b0; e_cclk = 1'b0; e_rdy = 1'b0;
      repeat (PH) @(posedge clk);
      e_prog_n = 1'b1;
      repeat (CLR) @(posedge clk);
      if (cfg_done) begin
         m_finish(2'd1);
         return;
      end
      while (rem > 0) begin
         e_rdy = 1'b1;
         do @(posedge clk); while (!in_valid);
         b = m_q[k];
         k++;
         rem--;
         e_rdy = 1'b0;
         if (hunt && b != 8'hFF) continue;
         hunt = 1'b0;
         for (int j = 7; j >= 0; j--) begin
            e_din = b[j]; e_cclk = 1'b0;
            repeat (PH) @(posedge clk);
            e_cclk = 1'b1;
            repeat (PH) @(posedge clk);
            e_cclk = 1'b0;
            repeat (PH) @(posedge clk);
         end
      end
      e_rdy = 1'b0;
      m_stage = 2;
      for (int t = 0; t < TRL; t++) begin
         e_cclk = 1'b1;
         repeat (PH) @(posedge clk);
         e_cclk = 1'b0;
         repeat (PH) @(posedge clk);
      end
      repeat (FIN) @(posedge clk);
      m_finish(cfg_done ? 2'd0 : 2'd2);
   endtask

   task automatic do_run(input logic [7:0] bytes[$], input int cnt, input bit wclr,
                         input bit wfin, input bit gap, input bit late_start,
                         input string tag, input int exp_stat, input int exp_pulses);
      drv_q = bytes; m_q = bytes; drv_idx = 0; gap_cnt = 0;
      m_cnt = cnt; want_clear = wclr; want_final = wfin; gap_mode = gap;
      @(negedge clk);
      pulses = 0;
      start = 1'b1;
      byte_cnt = 16'(cnt);
      @(posedge clk);
      fork
         model_run();
         begin
            @(negedge clk);
            start = 1'b0;
            if (late_start) begin
               repeat (40) @(negedge clk);
               start = 1'b1;
               @(negedge clk);
               start = 1'b0;
            end
         end
      join
      repeat (3) @(negedge clk);
      check({tag, " final status"}, 32'(status), 32'(exp_stat));
      check({tag, " clock pulses"}, 32'(pulses), 32'(exp_pulses));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset prog_n", 32'(cfg_prog_n), 32'd1);
      check("R1 reset cclk",   32'(cfg_cclk),   32'd0);
      check("R1 reset din",    32'(cfg_din),    32'd0);
      check("R1 reset busy",   32'(busy),       32'd0);
      chk_en = 1'b1;
      // R4 R5 R6 R7: header dropped, three payload bytes, success
      do_run('{8'h00, 8'h12, 8'h34, 8'hFF, 8'hA5, 8'h3C}, 6, 1'b0, 1'b1, 1'b0, 1'b0,
             "R4 R6 header+3", 0, 3*8 + TRL);
      // R3: done high after clear
      do_run('{8'hFF, 8'h55}, 2, 1'b1, 1'b1, 1'b0, 1'b0, "R3 done high", 1, 0);
      // R8: count exhausted before marker, then load fails
      do_run('{8'h11, 8'h22, 8'hFF}, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R8 no marker", 2, TRL);
      // R9 R10: gaps on valid, start pulse while busy
      do_run('{8'hFF, 8'h81}, 2, 1'b0, 1'b1, 1'b1, 1'b1, "R10 gaps+late start", 0, 2*8 + TRL);
      // R8: zero count
      do_run('{}, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 zero count", 0, TRL);
      // R7: single marker byte, done stays low
      do_run('{8'hFF}, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 load fail", 2, 8 + TRL);
      chk_en = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule